// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block produces a clocked cosine/sine pair whose frequency is set by a frequency control word. A 24-bit phase register adds the word once per enabled clock and wraps modulo 2^24. The top eight phase bits form a waveform address, and the lower sixteen bits are dropped. Both outputs come from one 64-entry quarter-wave table, read through two ports at the index and at its mirror. A quadrant stage swaps and negates those two reads to give the full cycle.

The cosine sample is meant for the real data input of a downstream complex transform, and the sine sample for its imaginary input. Each is a signed 16-bit value. The output frequency is fs·k/2^24, where k is the control word. Every sample is stamped by a valid flag that follows the enable two clocks later.

Top module: `nco_quad_top`

## Requirements
- R1: A synchronous active-high reset clears the phase to zero, drives `out_vld` low and drives both sample outputs to 0. The first enabled sample after reset uses phase 0.
- R2: Each clock with `en` high adds `fcw` to the phase modulo 2^24. The n-th valid sample after reset (n = 0, 1, ...) therefore uses phase n·fcw mod 2^24.
- R3: Only phase bits [23:16] form the waveform address a. The lower sixteen bits reach the output only through the carries they produce.
- R4: `cos_out` equals round(32767·cos(2π(a+0.5)/256)) within ±2 LSB.
- R5: `sin_out` equals round(32767·sin(2π(a+0.5)/256)) within ±2 LSB.
- R6: Neither output ever takes the value -32768.
- R7: `out_vld` is high exactly two clocks after a clock edge that samples `en` high, and low two clocks after an edge that samples it low.
- R8: On every valid sample, cos² + sin² lies within 32767² ± 65536.
- R9: While `out_vld` is low, both outputs hold their last values. While `en` is low, the phase holds, so the sample that follows continues the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and launch one sample |
| fcw | input | 24 | Frequency control word (phase step) |
| cos_out | output | 16 | Signed cosine sample, for the real input |
| sin_out | output | 16 | Signed sine sample, for the imaginary input |
| out_vld | output | 1 | Sample valid |

## Verification
The hard cases are the quadrant boundaries, where the address mirrors and the sign flips, and the long runs in which small words change only the discarded phase bits. A word of exactly one address step per sample walks every one of the 256 addresses in order, so all four quadrant folds and every table mirror get compared. Further sweeps cover a word just below one step, which repeats addresses through carries from the low bits, and a large odd word that wraps the phase many times. Gaps in the enable and a reset in the middle of a run test that the phase holds and that the sequence restarts at zero.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W = 24;
    localparam int ADDR_W  = 8;
    localparam int SAMP_W  = 16;
    localparam int QIDX_W  = ADDR_W - 2;
    localparam int QDEPTH  = 1 << QIDX_W;
    localparam int AMP     = (1 << (SAMP_W - 1)) - 1;

    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quad_e;

    typedef logic signed [SAMP_W-1:0] samp_t;

    // Operands for the quadrant stage: table read at the index (fwd) and at its mirror (rev)
    typedef struct packed {
        logic  vld;
        quad_e quad;
        samp_t fwd;
        samp_t rev;
    } fold_t;

    typedef struct packed {
        samp_t re;
        samp_t im;
    } iq_t;

    // Quarter-wave entry, sampled at half-step offsets so that mirroring stays exact
    function automatic int quarter_val(int idx);
        real ang;
        ang = 3.14159265358979323846 / 2.0 * (real'(idx) + 0.5) / real'(QDEPTH);
        return $rtoi($floor(real'(AMP) * $sin(ang) + 0.5));
    endfunction

    // Expand one quarter-wave pair into a full-cycle cosine/sine pair
    function automatic iq_t unfold(fold_t f);
        iq_t r;
        unique case (f.quad)
            QUAD_0: begin r.re =  f.rev; r.im =  f.fwd; end
            QUAD_1: begin r.re = -f.fwd; r.im =  f.rev; end
            QUAD_2: begin r.re = -f.rev; r.im = -f.fwd; end
            default: begin r.re =  f.fwd; r.im = -f.rev; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int P_W = PHASE_W,
    parameter int A_W = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [P_W-1:0] fcw,
    output logic [A_W-1:0] addr_o,
    output logic           addr_vld_o
);

    logic [P_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= '0;
            addr_o     <= '0;
            addr_vld_o <= 1'b0;
        end else begin
            addr_vld_o <= en;
            if (en) begin
                addr_o  <= phase_q[P_W-1 -: A_W];
                phase_q <= phase_q + fcw;
            end
        end
    end

    // R9: phase frozen while not enabled
    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_q));

    // R2: an enabled step launches an address and marks it valid
    assert_addr_launch_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> addr_vld_o);

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom
    import nco_pkg::*;
#(
    parameter int I_W = QIDX_W
) (
    input  logic [I_W-1:0] idx_i,
    output samp_t          fwd_o,
    output samp_t          rev_o
);

    localparam int DEPTH = 1 << I_W;

    samp_t tab [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        localparam samp_t ENTRY = samp_t'(quarter_val(g));
        assign tab[g] = ENTRY;
    end

    // Mirror index is the bitwise complement within the quarter
    assign fwd_o = tab[idx_i];
    assign rev_o = tab[~idx_i];

endmodule

// File: rtl/nco_quadrant_map.sv
module nco_quadrant_map
    import nco_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fold_t fold_i,
    output iq_t   iq_o,
    output logic  vld_o
);

    iq_t nxt;

    always_comb nxt = unfold(fold_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            iq_o  <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= fold_i.vld;
            if (fold_i.vld) iq_o <= nxt;
        end
    end

    // R9: outputs hold when no new sample arrives
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !fold_i.vld |=> $stable(iq_o));

endmodule

// File: rtl/nco_quad_top.sv
module nco_quad_top
    import nco_pkg::*;
#(
    parameter int P_W = PHASE_W,
    parameter int A_W = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [P_W-1:0]           fcw,
    output logic signed [SAMP_W-1:0] cos_out,
    output logic signed [SAMP_W-1:0] sin_out,
    output logic                     out_vld
);

    localparam int I_W = A_W - 2;
    localparam longint RAD2 = longint'(AMP) * longint'(AMP);

    logic [A_W-1:0] addr;
    logic           addr_vld;
    samp_t          rd_fwd, rd_rev;
    fold_t          fold;
    iq_t            iq;

    nco_phase_acc #(.P_W(P_W), .A_W(A_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .fcw        (fcw),
        .addr_o     (addr),
        .addr_vld_o (addr_vld)
    );

    nco_quarter_rom #(.I_W(I_W)) u_rom (
        .idx_i (addr[I_W-1:0]),
        .fwd_o (rd_fwd),
        .rev_o (rd_rev)
    );

    always_comb begin
        fold.vld  = addr_vld;
        fold.quad = quad_e'(addr[A_W-1 -: 2]);
        fold.fwd  = rd_fwd;
        fold.rev  = rd_rev;
    end

    nco_quadrant_map u_map (
        .clk    (clk),
        .rst    (rst),
        .fold_i (fold),
        .iq_o   (iq),
        .vld_o  (out_vld)
    );

    assign cos_out = iq.re;
    assign sin_out = iq.im;

    // R7: fixed two-clock latency from enable to valid
    assert_valid_lat_R7: assert property (@(posedge clk) disable iff (rst)
        en |-> ##2 out_vld);
    assert_idle_lat_R7: assert property (@(posedge clk) disable iff (rst)
        !en |-> ##2 !out_vld);

    // R6: most negative code never produced
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (cos_out != samp_t'(-(AMP + 1))) && (sin_out != samp_t'(-(AMP + 1))));

    // R8: quadrature pair stays on the unit circle
    assert_unit_circle_R8: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ((longint'(cos_out) * longint'(cos_out) + longint'(sin_out) * longint'(sin_out)
                      <= RAD2 + 65536) &&
                     (longint'(cos_out) * longint'(cos_out) + longint'(sin_out) * longint'(sin_out)
                      >= RAD2 - 65536)));

endmodule

// File: tb/nco_quad_top_tb.sv
`timescale 1ns/1ps
module nco_quad_top_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [23:0]        fcw = '0;
    logic signed [15:0] cos_out, sin_out;
    logic               out_vld;

    int checks = 0;
    int errors = 0;
    string phase_tag = "R1";

    always #5 clk = ~clk;

    nco_quad_top u_dut (
        .clk(clk), .rst(rst), .en(en), .fcw(fcw),
        .cos_out(cos_out), .sin_out(sin_out), .out_vld(out_vld)
    );

    // Reference: ideal phase sequence and two-clock delay, from the requirements
    logic [23:0] m_phase;
    logic        m_v1, m_v2;
    logic [7:0]  m_a1, m_a2;
    int          last_re, last_im;

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= '0; m_v1 <= 1'b0; m_v2 <= 1'b0; m_a1 <= '0; m_a2 <= '0;
        end else begin
            m_v1 <= en; m_v2 <= m_v1; m_a2 <= m_a1;
            if (en) begin
                m_a1    <= m_phase[23:16];
                m_phase <= m_phase + fcw;
            end
        end
    end

    function automatic int ref_wave(int a, bit want_sin);
        real ang;
        ang = 2.0 * 3.14159265358979323846 * (real'(a) + 0.5) / 256.0;
        if (want_sin) return $rtoi($floor(32767.0 * $sin(ang) + 0.5));
        return $rtoi($floor(32767.0 * $cos(ang) + 0.5));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual %0d expected %0d at %0t", req, phase_tag, act, exp_v, $time);
        end
    endtask

    task automatic observe();
        int er, ei, dr, di;
        chk(out_vld == m_v2, "R7 valid", int'(out_vld), int'(m_v2));
        if (m_v2) begin
            er = ref_wave(int'(m_a2), 1'b0);
            ei = ref_wave(int'(m_a2), 1'b1);
            dr = int'(cos_out) - er;
            di = int'(sin_out) - ei;
            chk(dr >= -2 && dr <= 2, "R4 cos", int'(cos_out), er);
            chk(di >= -2 && di <= 2, "R5 sin", int'(sin_out), ei);
            chk(int'(cos_out) != -32768 && int'(sin_out) != -32768, "R6 range", int'(cos_out), int'(sin_out));
            last_re = int'(cos_out);
            last_im = int'(sin_out);
        end else begin
            chk(int'(cos_out) == last_re, "R9 hold cos", int'(cos_out), last_re);
            chk(int'(sin_out) == last_im, "R9 hold sin", int'(sin_out), last_im);
        end
    endtask

    task automatic run(int n, bit en_v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            observe();
            en = en_v;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        repeat (2) @(negedge clk);
        phase_tag = "R1";
        chk(out_vld == 1'b0, "R1 reset valid", int'(out_vld), 0);
        chk(cos_out == 16'sd0, "R1 reset cos", int'(cos_out), 0);
        chk(sin_out == 16'sd0, "R1 reset sin", int'(sin_out), 0);
        last_re = 0; last_im = 0;
        rst = 1'b0;
        en  = 1'b0;
    endtask

    initial begin
        last_re = 0; last_im = 0;
        do_reset();
        // R1: first sample after reset uses phase zero (cos near full scale, sin small)
        fcw = 24'h010000;
        run(1, 1'b1);
        run(2, 1'b0);
        chk(out_vld && cos_out > 16'sd32700 && sin_out > 16'sd390 && sin_out < 16'sd415,
            "R1 first sample", int'(cos_out), 32764);

        // R4 and R5 over every address: one address step per sample, two full turns
        phase_tag = "R2 R4 R5 sweep";
        do_reset();
        run(520, 1'b1);

        // R3: step just below one address, low bits carry into the address
        phase_tag = "R3 truncation";
        fcw = 24'h00FFFF;
        run(400, 1'b1);
        fcw = 24'h000001;
        run(100, 1'b1);

        // R2: large odd word, many wraps
        phase_tag = "R2 wrap";
        fcw = 24'h7F3A91;
        run(300, 1'b1);
        fcw = 24'hFFFFFF;
        run(50, 1'b1);

        // R7 and R9: enable gaps, phase holds across them
        phase_tag = "R7 R9 gaps";
        fcw = 24'h0A3000;
        for (int k = 0; k < 40; k++) begin
            run(1 + (k % 3), 1'b1);
            run(1 + (k % 4), 1'b0);
        end

        // R1: reset mid-run restarts sequence at phase zero
        phase_tag = "R1 mid-run";
        do_reset();
        fcw = 24'h123457;
        run(60, 1'b1);
        run(4, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog [%s] actual %0d expected %0d", phase_tag, 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule